// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

The block is a small memory-mapped peripheral that produces two independent pulse-width modulated outputs. Software describes each waveform with two tick counts: how many prescaled ticks the output stays high, and how many it then stays low. Every period starts with the high phase and repeats until the channel is stopped. A shared control word holds, for each channel, a clock gate, a 7-bit prescaler and an output enable. A channel runs only while both its gate bits are set.

Software talks to the block over a simple 32-bit word bus with a word index, write strobe and combinational read-back of every register. Count-register writes never shorten a period in progress: the running channel takes the new counts only at the end of the current period. Stopping a channel drives its output low and parks its internal counters at zero, while its programmed counts and prescaler stay in place for the next start.

Top module: `twin_pwm`

## Requirements
- R1: Word index 0 is the channel A count word and index 1 the channel B count word, each with the high count in bits 31:16 and the low count in bits 15:0. Index 2 is the control word: bit 0 channel A output enable, bit 1 channel B output enable, bits 14:8 channel A prescaler, bit 15 channel A clock gate, bits 22:16 channel B prescaler, bit 23 channel B clock gate. All words read back what was written; unused control bits read 0 and index 3 reads 0 and ignores writes.
- R2: A synchronous active-high reset clears all three registers and forces both outputs low.
- R3: A running channel with prescaler field D, high count H and low count L drives its output high for H*(D+1) clock cycles and then low for L*(D+1) cycles, repeating; the period starts with the high phase in the first cycle after the enabling write.
- R4: A high count of 0 gives a constant-low output; a low count of 0 with a nonzero high count gives a constant-high output.
- R5: A channel runs only when both its clock gate bit and its output enable bit are 1; with either bit 0 its output is low.
- R6: Clearing a channel's output enable stops it without altering its count word or prescaler; a later restart begins again at the start of a high phase.
- R7: A count-word write during a period takes effect at the start of the next period; a write landing on the clock edge that ends a period takes effect one period later.
- R8: The two channels run independently; writing the control word to start or change one channel does not disturb the waveform of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 2 | Word index (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr, combinational |
| pwmA | output | 1 | Channel A waveform |
| pwmB | output | 1 | Channel B waveform |

## Verification
A software write to a count word and the channel's own end-of-period reload can fall in the same clock cycle. The bench provokes this by timing a write so it lands either in the middle of a period or exactly on the edge where the period ends, sampling the output every cycle. The mid-period case must switch to the new counts at the next period, while the boundary case must run one more full period of the old counts before the new ones appear.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 7;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] low;
  } chanCtl_t;
endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
  import twin_pwm_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output chanCtl_t          chanCtl [NUM_CH]
);
  localparam int CTRL_IDX = NUM_CH;
  localparam int GATE_STRIDE = 8;
  localparam int DIV_BASE = 8;

  logic [DATA_W-1:0] cntReg [NUM_CH];
  logic [NUM_CH-1:0] outEn;
  logic [NUM_CH-1:0] clkGate;
  logic [DIV_W-1:0]  preDiv [NUM_CH];
  logic [DATA_W-1:0] ctrlWord;
  logic              ctrlWrite;

  assign ctrlWrite = wrEn && (addr == IDX_W'(CTRL_IDX));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cntReg[ch]  <= '0;
        outEn[ch]   <= 1'b0;
        clkGate[ch] <= 1'b0;
        preDiv[ch]  <= '0;
      end else begin
        if (wrEn && (addr == IDX_W'(ch))) cntReg[ch] <= wdata;
        if (ctrlWrite) begin
          outEn[ch]   <= wdata[ch];
          preDiv[ch]  <= wdata[DIV_BASE + GATE_STRIDE*ch +: DIV_W];
          clkGate[ch] <= wdata[DIV_BASE + GATE_STRIDE*ch + DIV_W];
        end
      end
    end

    assign chanCtl[ch].run  = outEn[ch] && clkGate[ch];
    assign chanCtl[ch].div  = preDiv[ch];
    assign chanCtl[ch].high = cntReg[ch][2*CNT_W-1:CNT_W];
    assign chanCtl[ch].low  = cntReg[ch][CNT_W-1:0];
  end

  always_comb begin
    ctrlWord = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ctrlWord[ch] = outEn[ch];
      ctrlWord[DIV_BASE + GATE_STRIDE*ch +: DIV_W] = preDiv[ch];
      ctrlWord[DIV_BASE + GATE_STRIDE*ch + DIV_W] = clkGate[ch];
    end
  end

  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == IDX_W'(ch)) rdata = cntReg[ch];
    end
    if (addr == IDX_W'(CTRL_IDX)) rdata = ctrlWord;
  end
endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
  import twin_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  chanCtl_t ctl,
  output logic     pwmOut
);
  localparam int POS_W = CNT_W + 1;

  logic [DIV_W-1:0] preCnt;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] shHigh;
  logic [CNT_W-1:0] shLow;
  logic [POS_W-1:0] total;
  logic             tick;
  logic             periodEnd;

  assign total     = POS_W'(shHigh) + POS_W'(shLow);
  assign tick      = (preCnt >= ctl.div);
  assign periodEnd = ((pos + POS_W'(1)) >= total);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      pos    <= '0;
      shHigh <= '0;
      shLow  <= '0;
    end else if (!ctl.run) begin
      preCnt <= '0;
      pos    <= '0;
      shHigh <= ctl.high;
      shLow  <= ctl.low;
    end else if (tick) begin
      preCnt <= '0;
      if (periodEnd) begin
        pos    <= '0;
        shHigh <= ctl.high;
        shLow  <= ctl.low;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  assign pwmOut = ctl.run && (pos < POS_W'(shHigh));
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwmA,
  output logic              pwmB
);
  chanCtl_t          chanCtl [NUM_CH];
  logic [NUM_CH-1:0] pwmVec;
  logic [NUM_CH-1:0] runVec;

  twin_pwm_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .chanCtl(chanCtl)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    twin_pwm_chan u_chan (
      .clk(clk), .rst(rst), .ctl(chanCtl[ch]), .pwmOut(pwmVec[ch])
    );
    assign runVec[ch] = chanCtl[ch].run;
  end

  assign pwmA = pwmVec[0];
  assign pwmB = pwmVec[1];
endmodule

// File: rtl/twin_pwm_check.sv
module twin_pwm_check #(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [IDX_W-1:0]  addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              pwmA,
  input logic              pwmB,
  input logic [1:0]        runVec
);
  a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwmA && !pwmB && rdata == '0));

  a_r5_gated_low: assert property (@(posedge clk) disable iff (rst)
    (!runVec[0] |-> !pwmA) and (!runVec[1] |-> !pwmB));

  a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == '0) |=> (addr != '0 || rdata == $past(wdata)));

  a_r6_count_kept: assert property (@(posedge clk) disable iff (rst)
    (!(wrEn && addr == '0) && addr == '0) |=> (addr != '0 || $stable(rdata)));

  a_r3_rise_when_running: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwmA) |-> runVec[0]) and ($rose(pwmB) |-> runVec[1]));
endmodule

bind twin_pwm twin_pwm_check #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pwmA(pwmA), .pwmB(pwmB), .runVec(runVec)
);

// File: tb/twin_pwm_test.sv
module twin_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwmA, pwmB;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  twin_pwm uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwmA(pwmA), .pwmB(pwmB)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic        ch;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [6:0]  dv;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 16'd3, 16'd2, 7'd0},
    '{1'b1, 16'd1, 16'd1, 7'd2},
    '{1'b0, 16'd0, 16'd4, 7'd1},
    '{1'b1, 16'd5, 16'd0, 7'd0},
    '{1'b0, 16'd2, 16'd5, 7'd3},
    '{1'b1, 16'd4, 16'd1, 7'd127},
    '{1'b0, 16'd0, 16'd0, 7'd0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] idx, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; addr = idx; wdata = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    addr = idx;
    #1 data = rdata;
  endtask

  function automatic logic [31:0] ctrlFor(logic ch, logic [6:0] dv);
    return ch ? (32'h0080_0002 | (32'(dv) << 16)) : (32'h0000_8001 | (32'(dv) << 8));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int errs;
    int first;
    logic expA, expB;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    check("R2 outA", {31'd0, pwmA}, 0);
    check("R2 outB", {31'd0, pwmB}, 0);
    for (int i = 0; i < 3; i++) begin
      busRead(2'(i), rd);
      check("R2 regs", rd, 0);
    end

    // R1: map and read-back
    busWrite(2'd0, 32'h1234_5678);
    busWrite(2'd1, 32'hDEAD_BEEF);
    busRead(2'd0, rd); check("R1 cntA", rd, 32'h1234_5678);
    busRead(2'd1, rd); check("R1 cntB", rd, 32'hDEAD_BEEF);
    busWrite(2'd2, 32'hFFFF_FFFF);
    busRead(2'd2, rd); check("R1 ctrl", rd, 32'h00FF_FF03);
    busWrite(2'd3, 32'hA5A5_A5A5);
    busRead(2'd3, rd); check("R1 idx3", rd, 0);
    busRead(2'd0, rd); check("R1 idx3 no alias", rd, 32'h1234_5678);
    busWrite(2'd2, 32'h0);

    // R3/R4: vector walk
    foreach (VECS[v]) begin
      int p, hiCyc, n;
      busWrite(2'd2, 32'h0);
      busWrite(VECS[v].ch ? 2'd1 : 2'd0, {VECS[v].hi, VECS[v].lo});
      busWrite(2'd2, ctrlFor(VECS[v].ch, VECS[v].dv));
      p = (int'(VECS[v].hi) + int'(VECS[v].lo)) * (int'(VECS[v].dv) + 1);
      hiCyc = int'(VECS[v].hi) * (int'(VECS[v].dv) + 1);
      n = (p == 0) ? 20 : 2 * p;
      errs = 0; first = -1;
      for (int k = 0; k < n; k++) begin
        logic e, got, other;
        if (k > 0) @(negedge clk);
        e = (p != 0) && ((k % p) < hiCyc);
        got = VECS[v].ch ? pwmB : pwmA;
        other = VECS[v].ch ? pwmA : pwmB;
        if (got !== e || other !== 1'b0) begin
          errs++;
          if (first < 0) first = k;
        end
      end
      if (VECS[v].hi == 0 || VECS[v].lo == 0) check("R4 wave errors", errs, 0);
      else check("R3 wave errors", errs, 0);
      if (errs != 0) $display("  vector %0d first bad cycle %0d", v, first);
    end

    // R5: both gate bits needed
    busWrite(2'd2, 32'h0);
    busWrite(2'd0, {16'd3, 16'd3});
    busWrite(2'd2, 32'h0000_8000);
    errs = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (pwmA !== 1'b0) errs++; end
    check("R5 gate only", errs, 0);
    busWrite(2'd2, 32'h0000_0001);
    errs = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (pwmA !== 1'b0) errs++; end
    check("R5 enable only", errs, 0);

    // R6: stop keeps settings, restart from high phase
    busWrite(2'd2, 32'h0000_8501);
    repeat (7) @(negedge clk);
    busWrite(2'd2, 32'h0000_8500);
    errs = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (pwmA !== 1'b0) errs++; end
    check("R6 stopped low", errs, 0);
    busRead(2'd0, rd); check("R6 count kept", rd, {16'd3, 16'd3});
    busRead(2'd2, rd); check("R6 prescaler kept", rd, 32'h0000_8500);
    busWrite(2'd2, 32'h0000_8501);
    errs = 0;
    for (int k = 0; k < 36; k++) begin
      if (k > 0) @(negedge clk);
      if (pwmA !== ((k % 36) < 18)) errs++;
    end
    check("R6 restart phase", errs, 0);

    // R7: mid-period write
    busWrite(2'd2, 32'h0);
    busWrite(2'd0, {16'd4, 16'd4});
    busWrite(2'd2, 32'h0000_8001);
    errs = 0;
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      expA = (k < 8) ? ((k % 8) < 4) : (((k - 8) % 2) < 1);
      if (pwmA !== expA) errs++;
      if (k == 2) begin wrEn = 1'b1; addr = 2'd0; wdata = {16'd1, 16'd1}; end
      else wrEn = 1'b0;
    end
    wrEn = 1'b0;
    check("R7 mid-period write", errs, 0);

    // R7: write on the period-ending edge
    busWrite(2'd2, 32'h0);
    busWrite(2'd0, {16'd2, 16'd2});
    busWrite(2'd2, 32'h0000_8001);
    errs = 0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      expA = (k < 8) ? ((k % 4) < 2) : (((k - 8) % 4) < 1);
      if (pwmA !== expA) errs++;
      if (k == 3) begin wrEn = 1'b1; addr = 2'd0; wdata = {16'd1, 16'd3}; end
      else wrEn = 1'b0;
    end
    wrEn = 1'b0;
    check("R7 boundary write", errs, 0);

    // R8: start B while A runs
    busWrite(2'd2, 32'h0);
    busWrite(2'd0, {16'd2, 16'd2});
    busWrite(2'd1, {16'd1, 16'd1});
    busWrite(2'd2, 32'h0000_8001);
    errs = 0;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      expA = (k % 4) < 2;
      expB = (k >= 6) && (((k - 6) % 2) < 1);
      if (pwmA !== expA || pwmB !== expB) errs++;
      if (k == 5) begin wrEn = 1'b1; addr = 2'd2; wdata = 32'h0080_8003; end
      else wrEn = 1'b0;
    end
    wrEn = 1'b0;
    check("R8 independence", errs, 0);

    // R2: reset while running
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R2 run reset A", {31'd0, pwmA}, 0);
    check("R2 run reset B", {31'd0, pwmB}, 0);
    busRead(2'd2, rd); check("R2 run reset ctrl", rd, 0);
    busRead(2'd1, rd); check("R2 run reset cntB", rd, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule